// File: doc/BRIEF.md
# Speculative Mode Entry Filter

A core can hit a long-latency miss that blocks retirement. It can then either stall or switch into a speculative pre-execution mode that only warms caches and predictors. This block decides, in the same cycle the stall is reported, whether that switch is worthwhile. The aim is to cut the energy spent on speculative periods that are unlikely to produce new useful misses.

Two kinds of period are filtered out:

- **Late entry.** If the blocking miss has already been outstanding longer than an age limit, its data is close to returning. A period started now would be short, and its exit flush would cost more than it saves.
- **Overlapping entry.** The block counts the instructions pseudo-retired during the last speculative period. It also counts the instructions fetched since that period ended. If the core has not yet fetched past the point the last period reached, a new period would only repeat the same work, so entry is refused.

The age limit is a build-time constant by default. One build variant takes it from an input port instead, so it can be tuned at run time. Checkpointing, flushing, the memory system and any usefulness prediction stay with the surrounding core.

Top module: `spec_entry_filter`

## Requirements
- R1: After reset no speculative period is recorded: the recorded period length and the fetch count are both zero, and the mode is off. A request with age 0 is therefore granted.
- R2: With the constant limit variant (`DYN_LIMIT` = 0), a request whose `miss_age` is greater than `AGE_LIMIT` is refused. A request whose age equals `AGE_LIMIT` passes the age check.
- R3: With the run-time limit variant (`DYN_LIMIT` = 1), the age check compares `miss_age` against `age_limit_in` instead of `AGE_LIMIT`, with the same strictly-greater rule.
- R4: While in speculative mode, each cycle with `pretire_pulse` high adds one to the period count. The count is cleared when the mode is entered. On the exit cycle it is recorded, including a pulse given on that exit cycle.
- R5: Outside speculative mode, each cycle with `fetch_pulse` high adds one to the fetch count. The count is cleared on the exit cycle, and a fetch pulse on the exit cycle or during the mode is not counted.
- R6: A request is refused while the fetch count is less than the recorded period length. It passes this check once the fetch count is equal to or greater than that length.
- R7: Both counts saturate at 2^`CNT_W`-1 instead of wrapping.
- R8: `enter_ok` is low when `miss_req` is low, and low while the mode is already active.
- R9: `enter_ok` is combinational. It reflects the request and counter state of the same cycle, with no register between `miss_req` and `enter_ok`.
- R10: `pretire_pulse` outside speculative mode has no effect on the recorded period length.
- R11: `spec_enter` only takes effect while the mode is off, and `spec_exit` only takes effect while it is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_req | input | 1 | A long-latency miss is blocking retirement this cycle |
| miss_age | input | AGE_W | Cycles the blocking miss has been outstanding |
| age_limit_in | input | AGE_W | Run-time age limit (used only when DYN_LIMIT = 1) |
| fetch_pulse | input | 1 | One instruction fetched this cycle |
| pretire_pulse | input | 1 | One instruction pseudo-retired this cycle |
| spec_enter | input | 1 | Core enters speculative mode this cycle |
| spec_exit | input | 1 | Core leaves speculative mode this cycle |
| enter_ok | output | 1 | Entry permitted for the current request |

## Verification
The bench builds two copies side by side, both with `CNT_W` = 4 so that the counters reach saturation after a few tens of pulses. With saturation in reach, a wrap back to a small value would show up as a wrong verdict. One copy keeps the constant limit of 400 with `AGE_W` = 10, which puts both sides of the limit and the largest possible age within the probe range. The other copy uses the run-time limit, so the same stimulus shows the two limit sources giving different verdicts for the same miss age.

// File: rtl/spec_entry_filter_pkg.sv
package spec_entry_filter_pkg;

    // Outcome of one entry request, in priority order of refusal.
    typedef enum logic [1:0] {
        VERDICT_GRANT   = 2'd0,
        VERDICT_IDLE    = 2'd1,
        VERDICT_STALE   = 2'd2,
        VERDICT_OVERLAP = 2'd3
    } verdict_e;

    // Individual gate results feeding the verdict.
    typedef struct packed {
        logic requested;
        logic mode_busy;
        logic too_old;
        logic overlaps;
    } gate_flags_t;

    // Mode strobes after qualification with the current mode.
    typedef struct packed {
        logic enter_fire;
        logic exit_fire;
    } mode_events_t;

    function automatic verdict_e resolve_verdict(input gate_flags_t f);
        if (!f.requested || f.mode_busy) return VERDICT_IDLE;
        if (f.too_old)                   return VERDICT_STALE;
        if (f.overlaps)                  return VERDICT_OVERLAP;
        return VERDICT_GRANT;
    endfunction

    function automatic logic verdict_grants(input verdict_e v);
        return v == VERDICT_GRANT;
    endfunction

endpackage

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_after
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_q;

    // Value including this cycle's increment, held at TOP.
    always_comb begin
        if (inc && cnt_q != TOP) cnt_after = cnt_q + W'(1);
        else                     cnt_after = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst)      cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else          cnt_q <= cnt_after;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/mode_tracker.sv
module mode_tracker
    import spec_entry_filter_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         spec_enter,
    input  logic         spec_exit,
    output logic         in_spec,
    output mode_events_t events
);
    logic in_spec_q;

    always_comb begin
        events.enter_fire = spec_enter && !in_spec_q;
        events.exit_fire  = spec_exit  &&  in_spec_q;
    end

    always_ff @(posedge clk) begin
        if (rst)                    in_spec_q <= 1'b0;
        else if (events.enter_fire) in_spec_q <= 1'b1;
        else if (events.exit_fire)  in_spec_q <= 1'b0;
    end

    assign in_spec = in_spec_q;
endmodule

// File: rtl/period_tracker.sv
module period_tracker
    import spec_entry_filter_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_spec,
    input  mode_events_t     events,
    input  logic             pretire_pulse,
    input  logic             fetch_pulse,
    output logic [CNT_W-1:0] run_cnt,
    output logic [CNT_W-1:0] run_last,
    output logic [CNT_W-1:0] fetch_cnt
);
    logic [CNT_W-1:0] run_after;
    logic [CNT_W-1:0] fetch_after;
    logic [CNT_W-1:0] run_last_q;
    logic             run_inc;
    logic             fetch_inc;

    // Pseudo-retires only count inside a period.
    assign run_inc = pretire_pulse && in_spec;

    // Fetches only count outside a period, and never on the exit cycle.
    assign fetch_inc = fetch_pulse && !in_spec;

    sat_counter #(.W(CNT_W)) u_run_cnt (
        .clk       (clk),
        .rst       (rst),
        .clr       (events.enter_fire),
        .inc       (run_inc),
        .cnt       (run_cnt),
        .cnt_after (run_after)
    );

    sat_counter #(.W(CNT_W)) u_fetch_cnt (
        .clk       (clk),
        .rst       (rst),
        .clr       (events.exit_fire),
        .inc       (fetch_inc),
        .cnt       (fetch_cnt),
        .cnt_after (fetch_after)
    );

    // Length of the last completed period, captured with the exit-cycle pulse.
    always_ff @(posedge clk) begin
        if (rst)                   run_last_q <= '0;
        else if (events.exit_fire) run_last_q <= run_after;
    end

    assign run_last = run_last_q;

    logic unused_fetch_after;
    assign unused_fetch_after = ^fetch_after;
endmodule

// File: rtl/age_gate.sv
module age_gate #(
    parameter int AGE_W     = 10,
    parameter int AGE_LIMIT = 400,
    parameter bit DYN_LIMIT = 1'b0
) (
    input  logic [AGE_W-1:0] miss_age,
    input  logic [AGE_W-1:0] age_limit_in,
    output logic             too_old
);
    localparam logic [AGE_W-1:0] LIMIT_C = AGE_W'(AGE_LIMIT);

    logic [AGE_W-1:0] limit_sel;

    generate
        if (DYN_LIMIT) begin : g_dyn_limit
            assign limit_sel = age_limit_in;
        end else begin : g_const_limit
            logic unused_limit_in;
            assign unused_limit_in = ^age_limit_in;
            assign limit_sel       = LIMIT_C;
        end
    endgenerate

    assign too_old = miss_age > limit_sel;
endmodule

// File: rtl/spec_entry_filter.sv
module spec_entry_filter
    import spec_entry_filter_pkg::*;
#(
    parameter int AGE_W     = 10,
    parameter int CNT_W     = 12,
    parameter int AGE_LIMIT = 400,
    parameter bit DYN_LIMIT = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             miss_req,
    input  logic [AGE_W-1:0] miss_age,
    input  logic [AGE_W-1:0] age_limit_in,
    input  logic             fetch_pulse,
    input  logic             pretire_pulse,
    input  logic             spec_enter,
    input  logic             spec_exit,
    output logic             enter_ok
);
    logic             in_spec;
    mode_events_t     events;
    logic [CNT_W-1:0] run_cnt;
    logic [CNT_W-1:0] run_last;
    logic [CNT_W-1:0] fetch_cnt;
    logic             too_old;
    gate_flags_t      flags;
    verdict_e         verdict;

    mode_tracker u_mode (
        .clk        (clk),
        .rst        (rst),
        .spec_enter (spec_enter),
        .spec_exit  (spec_exit),
        .in_spec    (in_spec),
        .events     (events)
    );

    period_tracker #(.CNT_W(CNT_W)) u_period (
        .clk           (clk),
        .rst           (rst),
        .in_spec       (in_spec),
        .events        (events),
        .pretire_pulse (pretire_pulse),
        .fetch_pulse   (fetch_pulse),
        .run_cnt       (run_cnt),
        .run_last      (run_last),
        .fetch_cnt     (fetch_cnt)
    );

    age_gate #(
        .AGE_W     (AGE_W),
        .AGE_LIMIT (AGE_LIMIT),
        .DYN_LIMIT (DYN_LIMIT)
    ) u_age (
        .miss_age     (miss_age),
        .age_limit_in (age_limit_in),
        .too_old      (too_old)
    );

    always_comb begin
        flags.requested = miss_req;
        flags.mode_busy = in_spec;
        flags.too_old   = too_old;
        flags.overlaps  = fetch_cnt < run_last;
        verdict         = resolve_verdict(flags);
    end

    assign enter_ok = verdict_grants(verdict);
endmodule

// File: rtl/spec_entry_filter_chk.sv
module spec_entry_filter_chk #(
    parameter int AGE_W     = 10,
    parameter int CNT_W     = 12,
    parameter int AGE_LIMIT = 400,
    parameter bit DYN_LIMIT = 1'b0
) (
    input logic             clk,
    input logic             rst,
    input logic             miss_req,
    input logic [AGE_W-1:0] miss_age,
    input logic [AGE_W-1:0] age_limit_in,
    input logic             fetch_pulse,
    input logic             pretire_pulse,
    input logic             spec_enter,
    input logic             spec_exit,
    input logic             enter_ok,
    input logic             in_spec,
    input logic [CNT_W-1:0] run_cnt,
    input logic [CNT_W-1:0] run_last,
    input logic [CNT_W-1:0] fetch_cnt
);
    localparam logic [CNT_W-1:0] TOP     = {CNT_W{1'b1}};
    localparam logic [AGE_W-1:0] LIMIT_C = AGE_W'(AGE_LIMIT);

    logic [AGE_W-1:0] lim;
    assign lim = DYN_LIMIT ? age_limit_in : LIMIT_C;

    // R2 / R3
    assert_old_refused_R2: assert property (@(posedge clk) disable iff (rst)
        (miss_req && miss_age > lim) |-> !enter_ok);

    // R8
    assert_busy_refused_R8: assert property (@(posedge clk) disable iff (rst)
        (in_spec || !miss_req) |-> !enter_ok);

    // R6
    assert_overlap_refused_R6: assert property (@(posedge clk) disable iff (rst)
        (fetch_cnt < run_last) |-> !enter_ok);

    // R5
    assert_fetch_cleared_R5: assert property (@(posedge clk) disable iff (rst)
        (spec_exit && in_spec) |=> fetch_cnt == '0);

    // R7
    assert_fetch_sat_R7: assert property (@(posedge clk) disable iff (rst)
        (fetch_cnt == TOP && !(spec_exit && in_spec)) |=> fetch_cnt == TOP);

    // R7
    assert_run_sat_R7: assert property (@(posedge clk) disable iff (rst)
        (run_cnt == TOP && !(spec_enter && !in_spec)) |=> run_cnt == TOP);

    // R4: the recorded length only moves on an exit
    assert_last_held_R4: assert property (@(posedge clk) disable iff (rst)
        !(spec_exit && in_spec) |=> $stable(run_last));

    // R10
    assert_no_count_outside_R10: assert property (@(posedge clk) disable iff (rst)
        (!in_spec && !spec_enter) |=> $stable(run_cnt));

    // R11
    assert_enter_effect_R11: assert property (@(posedge clk) disable iff (rst)
        (!in_spec && spec_enter) |=> in_spec);
endmodule

bind spec_entry_filter spec_entry_filter_chk #(
    .AGE_W     (AGE_W),
    .CNT_W     (CNT_W),
    .AGE_LIMIT (AGE_LIMIT),
    .DYN_LIMIT (DYN_LIMIT)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .miss_req      (miss_req),
    .miss_age      (miss_age),
    .age_limit_in  (age_limit_in),
    .fetch_pulse   (fetch_pulse),
    .pretire_pulse (pretire_pulse),
    .spec_enter    (spec_enter),
    .spec_exit     (spec_exit),
    .enter_ok      (enter_ok),
    .in_spec       (in_spec),
    .run_cnt       (run_cnt),
    .run_last      (run_last),
    .fetch_cnt     (fetch_cnt)
);

// File: tb/spec_entry_filter_tb.sv
module spec_entry_filter_tb;
    localparam int AGE_W = 10;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             miss_req = 1'b0;
    logic [AGE_W-1:0] miss_age = '0;
    logic [AGE_W-1:0] age_limit_in = '1;
    logic             fetch_pulse = 1'b0;
    logic             pretire_pulse = 1'b0;
    logic             spec_enter = 1'b0;
    logic             spec_exit = 1'b0;
    logic             ok_s;
    logic             ok_d;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    spec_entry_filter #(.AGE_W(AGE_W), .CNT_W(CNT_W), .AGE_LIMIT(400), .DYN_LIMIT(1'b0)) u_dut (
        .clk(clk), .rst(rst), .miss_req(miss_req), .miss_age(miss_age),
        .age_limit_in(age_limit_in), .fetch_pulse(fetch_pulse),
        .pretire_pulse(pretire_pulse), .spec_enter(spec_enter),
        .spec_exit(spec_exit), .enter_ok(ok_s)
    );

    spec_entry_filter #(.AGE_W(AGE_W), .CNT_W(CNT_W), .AGE_LIMIT(400), .DYN_LIMIT(1'b1)) u_dyn (
        .clk(clk), .rst(rst), .miss_req(miss_req), .miss_age(miss_age),
        .age_limit_in(age_limit_in), .fetch_pulse(fetch_pulse),
        .pretire_pulse(pretire_pulse), .spec_enter(spec_enter),
        .spec_exit(spec_exit), .enter_ok(ok_d)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: enter_ok actual=%b expected=%b", req, act, exp);
        end
    endtask

    // One cycle of strobes, applied after the falling edge.
    task automatic cyc(input logic en, input logic ex, input logic f, input logic p);
        @(negedge clk);
        miss_req      = 1'b0;
        spec_enter    = en;
        spec_exit     = ex;
        fetch_pulse   = f;
        pretire_pulse = p;
    endtask

    task automatic cycles(input int n, input logic f, input logic p);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, f, p);
    endtask

    // Same-cycle probe of the combinational verdict on both copies.
    task automatic probe(input logic [AGE_W-1:0] age, input logic exp_s,
                         input logic exp_d, input string req);
        cyc(1'b0, 1'b0, 1'b0, 1'b0);
        miss_req = 1'b1;
        miss_age = age;
        #1;
        check({req, " const"}, ok_s, exp_s);
        check({req, " dyn"},   ok_d, exp_d);
        miss_req = 1'b0;
    endtask

    task automatic t_reset();
        // R1: empty history, age 0 granted
        probe(10'd0, 1'b1, 1'b1, "R1 reset grant");
        // R8: no request
        #1;
        check("R8 no request", ok_s, 1'b0);
        // R9: verdict follows the request within the cycle
        miss_req = 1'b1; miss_age = '0; #1;
        check("R9 same cycle", ok_s, 1'b1);
        miss_req = 1'b0;
    endtask

    task automatic t_age();
        age_limit_in = '1;
        probe(10'd400,  1'b1, 1'b1, "R2 age at limit");
        probe(10'd401,  1'b0, 1'b1, "R2 age over limit");
        probe(10'd1023, 1'b0, 1'b1, "R2 max age");
    endtask

    task automatic t_dyn();
        age_limit_in = 10'd50;
        probe(10'd50, 1'b1, 1'b1, "R3 dyn at limit");
        probe(10'd51, 1'b1, 1'b0, "R3 dyn over limit");
        age_limit_in = '1;
    endtask

    task automatic t_overlap();
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        probe(10'd0, 1'b0, 1'b0, "R8 busy in mode");
        cycles(3, 1'b0, 1'b1);
        cyc(1'b0, 1'b1, 1'b0, 1'b1);   // exit with a pulse: R = 4
        probe(10'd0, 1'b0, 1'b0, "R6 N=0 < R=4");
        cycles(3, 1'b1, 1'b0);
        probe(10'd0, 1'b0, 1'b0, "R6 N=3 < R=4");
        cycles(1, 1'b1, 1'b0);
        probe(10'd0, 1'b1, 1'b1, "R4 R6 N=4 == R=4");
        // exit-cycle fetch ignored
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        cycles(2, 1'b0, 1'b1);
        cyc(1'b0, 1'b1, 1'b1, 1'b0);   // R = 2, fetch dropped
        cycles(1, 1'b1, 1'b0);
        probe(10'd0, 1'b0, 1'b0, "R5 exit fetch ignored");
        cycles(1, 1'b1, 1'b0);
        probe(10'd0, 1'b1, 1'b1, "R5 N=2 == R=2");
    endtask

    task automatic t_ignore();
        cycles(5, 1'b0, 1'b1);
        probe(10'd0, 1'b1, 1'b1, "R10 pretire outside ignored");
        // repeated enter while busy, fetches during mode ignored
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, 1'b0, 1'b1, 1'b1);
        cycles(4, 1'b1, 1'b0);
        cyc(1'b0, 1'b1, 1'b0, 1'b0);   // R = 1
        probe(10'd0, 1'b0, 1'b0, "R5 R11 fetch in mode not counted");
        cycles(1, 1'b1, 1'b0);
        probe(10'd0, 1'b1, 1'b1, "R4 count cleared on entry");
        // exit while idle has no effect
        cyc(1'b0, 1'b1, 1'b0, 1'b0);
        probe(10'd0, 1'b1, 1'b1, "R11 idle exit ignored");
    endtask

    task automatic t_sat();
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        cycles(20, 1'b0, 1'b1);
        cyc(1'b0, 1'b1, 1'b0, 1'b0);   // R saturates at 15
        cycles(14, 1'b1, 1'b0);
        probe(10'd0, 1'b0, 1'b0, "R7 R saturated N=14");
        cycles(1, 1'b1, 1'b0);
        probe(10'd0, 1'b1, 1'b1, "R7 N=15 == R");
        cycles(10, 1'b1, 1'b0);
        probe(10'd0, 1'b1, 1'b1, "R7 N saturated");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_age();
        t_dyn();
        t_overlap();
        t_ignore();
        t_sat();
        cyc(1'b0, 1'b0, 1'b0, 1'b0);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule